// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a processor-style watchdog. It has no down-counter. It keeps a free-running 64-bit timebase that advances by one on every clock in which the tick input is high. Software chooses one bit of that timebase through a 6-bit period value. Each 0-to-1 transition of the chosen bit is one expiry event. A larger period watches a lower, faster-toggling bit. Period zero watches the top bit, which gives the longest timeout.

Expiry events escalate in three steps. The first event only arms the watchdog by setting an enable-next status flag. The second event sets an interrupt-status flag, which drives the interrupt output when interrupts are enabled. The third event issues a one-cycle reset request if a reset-control field has been programmed. That field is write-once. Software keeps the watchdog quiet by writing ones to clear both status flags before the next expiry.

When a reset request fires, the block copies the reset-control value into a reset-cause field. The system reset clears the control register and the two status flags, but it leaves the reset-cause field intact. Software can therefore read why the last reset happened. Only the power-on reset clears the reset-cause field.

Top module: `escWdog`

## Requirements
- R1: The 6-bit period is made of control bits 31:30 (low two bits) and control bits 20:17 (high four bits). It selects timebase bit 63 minus period. The timebase is cleared by power-on reset and increments on each clock with `tbTick` high. A 0-to-1 change of the selected bit is one expiry event.
- R2: An expiry event while enable-next (status bit 31) is clear sets enable-next. It changes no other status bit and raises neither output.
- R3: An expiry event while enable-next is set and interrupt-status (status bit 30) is clear sets interrupt-status.
- R4: An expiry event while both flags are set and reset-control (control bits 29:28) is non-zero does two things. It raises `rstReqOut` for exactly one cycle, and it copies reset-control into reset-cause (status bits 29:28). If reset-control is zero, the event has no effect.
- R5: `irqOut` is high exactly while interrupt-status and interrupt-enable (control bit 26) are both set. It stays high until software clears the flag.
- R6: A write to the status register (`regAddr`=1) clears each of bits 31, 30, 29 and 28 that is written as 1. Bits written as 0 keep their value.
- R7: Once reset-control is non-zero, control writes leave it unchanged until a reset. The other control fields still update.
- R8: A low `sysRstN` clears the control register, enable-next and interrupt-status, but it keeps reset-cause. A low `porN` also clears reset-cause and the timebase.
- R9: A control write that changes the period does not count the switch between watched bits as an expiry event. Later transitions of the new bit count normally.
- R10: Reads are combinational. `regAddr`=0 returns the control register, with period, interrupt-enable and reset-control at their bit positions. `regAddr`=1 returns status bits 31:28. Every other bit reads 0, and control bits outside those fields are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sysRstN | input | 1 | System reset, active low, asynchronous; keeps the reset-cause field |
| tbTick | input | 1 | Timebase advance enable |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 status |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| irqOut | output | 1 | Level watchdog interrupt |
| rstReqOut | output | 1 | One-cycle reset request |

## Verification
The bound checker enforces four rules on every cycle:
- a reset request lasts a single cycle, and only follows a cycle in which both flags and a non-zero reset-control were held;
- interrupt-status rises only after enable-next was already set;
- once reset-control is non-zero it never changes;
- the interrupt output implies interrupt-enable.

The bench scenarios cover what a per-cycle property cannot easily state. They check the exact escalation count against timebase arithmetic for two period settings, including a period split across both bit fields. They show that a period switch is suppressed as an event. They show that writes of zero leave status untouched, and that reset-cause survives a system reset but not a power-on reset.

// File: rtl/escWdogPkg.sv
package escWdogPkg;
  // Period field width; the timebase width follows from it.
  localparam int PER_W  = 6;
  localparam int TB_W   = 1 << PER_W;
  localparam int DATA_W = 32;
  localparam int RC_W   = 2;

  // Control register field positions.
  localparam int CTL_PLO_HI = 31;
  localparam int CTL_PLO_LO = 30;
  localparam int CTL_PHI_HI = 20;
  localparam int CTL_PHI_LO = 17;
  localparam int CTL_RC_HI  = 29;
  localparam int CTL_RC_LO  = 28;
  localparam int CTL_IE     = 26;

  // Status register field positions.
  localparam int ST_ENW   = 31;
  localparam int ST_WIS   = 30;
  localparam int ST_RS_HI = 29;
  localparam int ST_RS_LO = 28;

  typedef struct packed {
    logic setEnw;
    logic setWis;
    logic fireRst;
  } wdStrobe_t;
endpackage

// File: rtl/escWdogRegs.sv
module escWdogRegs
  import escWdogPkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRstN,
  input  logic              tbTick,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  wdStrobe_t         strobe,
  output logic              watchBit,
  output logic              periodMoved,
  output logic              enwLive,
  output logic              wisLive,
  output logic              ctlWie,
  output logic [RC_W-1:0]   ctlWrc,
  output logic              statEnw,
  output logic              statWis,
  output logic [RC_W-1:0]   statWrs
);
  logic            ctlRstN;
  logic [TB_W-1:0] tbCnt;
  logic [PER_W-1:0] perQ;
  logic [PER_W-1:0] newPer;
  logic [PER_W-1:0] watchIdx;
  logic            wieQ;
  logic [RC_W-1:0] wrcQ;
  logic            enwQ;
  logic            wisQ;
  logic [RC_W-1:0] wrsQ;
  logic            wrCtl;
  logic            wrStat;
  logic            unusedWrBits;

  assign ctlRstN = porN & sysRstN;
  assign wrCtl   = regWe & ~regAddr;
  assign wrStat  = regWe & regAddr;

  // The period is scattered over two control fields.
  assign newPer = {regWrData[CTL_PHI_HI:CTL_PHI_LO], regWrData[CTL_PLO_HI:CTL_PLO_LO]};

  // Bit (TB_W-1 - period); with TB_W a power of two this is the inverted period.
  assign watchIdx    = ~perQ;
  assign watchBit    = tbCnt[watchIdx];
  assign periodMoved = wrCtl && (newPer != perQ);

  // Status flags after this cycle's write-one-to-clear.
  assign enwLive = enwQ & ~(wrStat & regWrData[ST_ENW]);
  assign wisLive = wisQ & ~(wrStat & regWrData[ST_WIS]);

  assign unusedWrBits = ^{regWrData[27], regWrData[25:21], regWrData[16:0]};

  // Free-running timebase, cleared only at power-on.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) tbCnt <= '0;
    else if (tbTick) tbCnt <= tbCnt + 1'b1;
  end

  // Control register.
  always_ff @(posedge clk or negedge ctlRstN) begin
    if (!ctlRstN) begin
      perQ <= '0;
      wieQ <= 1'b0;
      wrcQ <= '0;
    end else if (wrCtl) begin
      perQ <= newPer;
      wieQ <= regWrData[CTL_IE];
      if (wrcQ == '0) wrcQ <= regWrData[CTL_RC_HI:CTL_RC_LO];
    end
  end

  // Escalation flags.
  always_ff @(posedge clk or negedge ctlRstN) begin
    if (!ctlRstN) begin
      enwQ <= 1'b0;
      wisQ <= 1'b0;
    end else begin
      enwQ <= enwLive | strobe.setEnw;
      wisQ <= wisLive | strobe.setWis;
    end
  end

  // Reset cause survives the system reset.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) wrsQ <= '0;
    else if (strobe.fireRst) wrsQ <= wrcQ;
    else if (wrStat) wrsQ <= wrsQ & ~regWrData[ST_RS_HI:ST_RS_LO];
  end

  always_comb begin
    regRdData = '0;
    if (!regAddr) begin
      regRdData[CTL_PLO_HI:CTL_PLO_LO] = perQ[1:0];
      regRdData[CTL_PHI_HI:CTL_PHI_LO] = perQ[PER_W-1:2];
      regRdData[CTL_RC_HI:CTL_RC_LO]   = wrcQ;
      regRdData[CTL_IE]                = wieQ;
    end else begin
      regRdData[ST_ENW]            = enwQ;
      regRdData[ST_WIS]            = wisQ;
      regRdData[ST_RS_HI:ST_RS_LO] = wrsQ;
    end
  end

  assign ctlWie  = wieQ;
  assign ctlWrc  = wrcQ;
  assign statEnw = enwQ;
  assign statWis = wisQ;
  assign statWrs = wrsQ;
endmodule

// File: rtl/escWdogCtrl.sv
module escWdogCtrl
  import escWdogPkg::*;
(
  input  logic            clk,
  input  logic            porN,
  input  logic            sysRstN,
  input  logic            watchBit,
  input  logic            periodMoved,
  input  logic            enwLive,
  input  logic            wisLive,
  input  logic [RC_W-1:0] ctlWrc,
  output wdStrobe_t       strobe,
  output logic            rstReqOut
);
  logic ctlRstN;
  logic prevQ;
  logic skipQ;
  logic rstQ;
  logic expiry;

  assign ctlRstN = porN & sysRstN;

  // Edge detector; the cycle after a period switch compares unrelated bits, so skip it.
  always_ff @(posedge clk or negedge ctlRstN) begin
    if (!ctlRstN) begin
      prevQ <= 1'b0;
      skipQ <= 1'b1;
    end else begin
      prevQ <= watchBit;
      skipQ <= periodMoved;
    end
  end

  assign expiry = watchBit & ~prevQ & ~skipQ;

  always_comb begin
    strobe.setEnw  = expiry & ~enwLive;
    strobe.setWis  = expiry & enwLive & ~wisLive;
    strobe.fireRst = expiry & enwLive & wisLive & (ctlWrc != '0);
  end

  always_ff @(posedge clk or negedge ctlRstN) begin
    if (!ctlRstN) rstQ <= 1'b0;
    else rstQ <= strobe.fireRst;
  end

  assign rstReqOut = rstQ;
endmodule

// File: rtl/escWdog.sv
module escWdog
  import escWdogPkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRstN,
  input  logic              tbTick,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              rstReqOut
);
  wdStrobe_t       strobe;
  logic            watchBit;
  logic            periodMoved;
  logic            enwLive;
  logic            wisLive;
  logic            ctlWie;
  logic [RC_W-1:0] ctlWrc;
  logic            statEnw;
  logic            statWis;
  logic [RC_W-1:0] statWrs;

  escWdogRegs uRegs (
    .clk(clk), .porN(porN), .sysRstN(sysRstN), .tbTick(tbTick),
    .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .watchBit(watchBit), .periodMoved(periodMoved),
    .enwLive(enwLive), .wisLive(wisLive), .ctlWie(ctlWie), .ctlWrc(ctlWrc),
    .statEnw(statEnw), .statWis(statWis), .statWrs(statWrs)
  );

  escWdogCtrl uCtrl (
    .clk(clk), .porN(porN), .sysRstN(sysRstN), .watchBit(watchBit),
    .periodMoved(periodMoved), .enwLive(enwLive), .wisLive(wisLive),
    .ctlWrc(ctlWrc), .strobe(strobe), .rstReqOut(rstReqOut)
  );

  assign irqOut = statWis & ctlWie;
endmodule

// File: rtl/escWdogChk.sv
module escWdogChk
  import escWdogPkg::*;
(
  input logic            clk,
  input logic            porN,
  input logic            sysRstN,
  input logic            irqOut,
  input logic            rstReqOut,
  input logic            statEnw,
  input logic            statWis,
  input logic            ctlWie,
  input logic [RC_W-1:0] ctlWrc
);
  // R4
  rst_single_pulse_chk: assert property (@(posedge clk) disable iff (!porN || !sysRstN)
    rstReqOut |=> !rstReqOut);

  // R4
  rst_needs_stage_chk: assert property (@(posedge clk) disable iff (!porN || !sysRstN)
    rstReqOut |-> $past(statEnw && statWis && (ctlWrc != '0)));

  // R3
  wis_after_enw_chk: assert property (@(posedge clk) disable iff (!porN || !sysRstN)
    $rose(statWis) |-> $past(statEnw));

  // R7
  wrc_locked_chk: assert property (@(posedge clk) disable iff (!porN || !sysRstN)
    ($past(ctlWrc) != '0) |-> $stable(ctlWrc));

  // R5
  irq_gated_chk: assert property (@(posedge clk) disable iff (!porN || !sysRstN)
    irqOut |-> ctlWie);
endmodule

bind escWdog escWdogChk uChk (
  .clk(clk), .porN(porN), .sysRstN(sysRstN), .irqOut(irqOut), .rstReqOut(rstReqOut),
  .statEnw(statEnw), .statWis(statWis), .ctlWie(ctlWie), .ctlWrc(ctlWrc)
);

// File: tb/escWdog_test.sv
module escWdog_test;
  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        sysRstN = 1'b1;
  logic        tbTick = 1'b0;
  logic        regWe = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;
  logic        rstReqOut;

  int checks = 0;
  int fails = 0;
  int rstCycles = 0;
  bit done = 0;

  // Reference model of the requirements.
  longint unsigned mTb = 0;
  int   mPer = 0;
  bit   mWie = 0;
  logic [1:0] mWrc = 0;
  bit   mEnw = 0;
  bit   mWis = 0;
  logic [1:0] mWrs = 0;
  int   mRst = 0;

  typedef struct packed {
    logic       clr;
    logic [3:0] ticks;
    logic [3:0] expStat;
    logic       expIrq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 4'd1, 4'b1000, 1'b0},
    '{1'b0, 4'd1, 4'b1000, 1'b0},
    '{1'b0, 4'd1, 4'b1100, 1'b1},
    '{1'b0, 4'd2, 4'b1100, 1'b1},
    '{1'b1, 4'd1, 4'b0000, 1'b0},
    '{1'b0, 4'd1, 4'b1000, 1'b0}
  };

  escWdog uut (
    .clk(clk), .porN(porN), .sysRstN(sysRstN), .tbTick(tbTick), .regWe(regWe),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rstReqOut) rstCycles++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] ctlWord(int per, bit wie, logic [1:0] wrc);
    logic [31:0] w = '0;
    logic [5:0] p = 6'(per);
    w[31:30] = p[1:0];
    w[20:17] = p[5:2];
    w[29:28] = wrc;
    w[26] = wie;
    return w;
  endfunction

  task automatic readReg(bit addr, output logic [31:0] val);
    @(negedge clk);
    regAddr = addr;
    #1;
    val = regRdData;
  endtask

  task automatic writeReg(bit addr, logic [31:0] d);
    @(negedge clk);
    regAddr = addr;
    regWrData = d;
    regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    regWrData = '0;
    if (!addr) begin
      mPer = {d[20:17], d[31:30]};
      mWie = d[26];
      if (mWrc == 2'b00) mWrc = d[29:28];
    end else begin
      if (d[31]) mEnw = 0;
      if (d[30]) mWis = 0;
      mWrs = mWrs & ~d[29:28];
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      int idx = 63 - mPer;
      bit b0 = mTb[idx];
      bit b1;
      @(negedge clk);
      tbTick = 1'b1;
      @(negedge clk);
      tbTick = 1'b0;
      mTb++;
      b1 = mTb[idx];
      if (!b0 && b1) begin
        if (!mEnw) mEnw = 1;
        else if (!mWis) mWis = 1;
        else if (mWrc != 2'b00) begin mWrs = mWrc; mRst++; end
      end
    end
    settle(2);
  endtask

  function automatic logic [31:0] modelStat();
    return {mEnw, mWis, mWrs, 28'b0};
  endfunction

  initial begin
    #(5ns * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    settle(3);
    porN = 1'b1;
    settle(2);

    // Reset state (R8, R10)
    readReg(0, v); chk("R8 reset ctl", v, 32'h0);
    readReg(1, v); chk("R8 reset status", v, 32'h0);
    chk("R5 reset irq", {31'b0, irqOut}, 32'h0);
    chk("R4 reset rstReq", {31'b0, rstReqOut}, 32'h0);

    // Period 63 watches bit 0; walk the vector table (R1 R2 R3 R4 R5 R6)
    writeReg(0, ctlWord(63, 1, 2'b00));
    settle(2);
    foreach (VECS[k]) begin
      if (VECS[k].clr) writeReg(1, 32'hC000_0000);
      tick(int'(VECS[k].ticks));
      readReg(1, v);
      chk($sformatf("R2 R3 table row %0d status", k), v, {VECS[k].expStat, 28'b0});
      chk($sformatf("R5 table row %0d irq", k), {31'b0, irqOut}, {31'b0, VECS[k].expIrq});
    end
    chk("R4 no reset with zero reset-control", rstCycles, 0);

    // Split period field and unstored bits (R10, R1)
    writeReg(1, 32'hC000_0000);
    writeReg(0, 32'h8FFF_FFFF);
    readReg(0, v); chk("R10 ctl readback", v, 32'h841E_0000);
    readReg(1, v); chk("R10 status reads zero", v, 32'h0);
    tick(3);
    readReg(1, v); chk("R1 period 62 first event", v, 32'h8000_0000);
    chk("R1 model agrees period 62", v, modelStat());
    tick(4);
    readReg(1, v); chk("R3 period 62 second event", v, 32'hC000_0000);

    // Interrupt enable gating (R5)
    writeReg(0, ctlWord(62, 0, 2'b00));
    settle(1);
    chk("R5 irq masked", {31'b0, irqOut}, 32'h0);
    writeReg(0, ctlWord(62, 1, 2'b00));
    settle(3);
    chk("R5 irq level held", {31'b0, irqOut}, 32'h1);

    // W1C details (R6)
    writeReg(1, 32'h0);
    readReg(1, v); chk("R6 zero write keeps status", v, 32'hC000_0000);
    writeReg(1, 32'h4000_0000);
    readReg(1, v); chk("R6 clear interrupt-status only", v, 32'h8000_0000);
    chk("R5 irq drops on clear", {31'b0, irqOut}, 32'h0);

    // Write-once reset control (R7)
    writeReg(0, ctlWord(62, 1, 2'b10));
    readReg(0, v); chk("R7 first reset-control write", v, 32'hA41E_0000);
    writeReg(0, ctlWord(62, 1, 2'b01));
    readReg(0, v); chk("R7 reset-control locked", v, 32'hA41E_0000);

    // Escalate to reset (R4)
    rstCycles = 0;
    for (int g = 0; g < 40 && mRst == 0; g++) tick(1);
    chk("R4 model reached reset", mRst, 1);
    chk("R4 single-cycle reset request", rstCycles, 1);
    readReg(1, v); chk("R4 reset cause recorded", v, 32'hE000_0000);

    // System reset keeps cause; power-on clears it (R8)
    @(negedge clk); sysRstN = 1'b0;
    settle(2); sysRstN = 1'b1;
    mPer = 0; mWie = 0; mWrc = 0; mEnw = 0; mWis = 0;
    settle(1);
    readReg(0, v); chk("R8 sysRst clears ctl", v, 32'h0);
    readReg(1, v); chk("R8 sysRst keeps cause", v, 32'h2000_0000);
    @(negedge clk); porN = 1'b0;
    settle(2); porN = 1'b1;
    mTb = 0; mWrs = 0;
    settle(1);
    readReg(1, v); chk("R8 power-on clears cause", v, 32'h0);

    // Period switch is not an event (R9)
    tick(1);
    writeReg(0, ctlWord(63, 1, 2'b00));
    settle(3);
    readReg(1, v); chk("R9 no event on period switch", v, 32'h0);
    tick(2);
    readReg(1, v); chk("R9 later edge counts", v, 32'h8000_0000);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule